// File: doc/BRIEF.md
# Two-Wire Serial Control Slave

This block is the control port that a host microcontroller uses to program a video back-end. The link has two wires. The host drives a shift clock, which toggles only during a transfer. One data line carries bits in both directions. Every transfer opens with an address byte, least significant bit first. The address value alone decides what follows:
- An address in the configuration range is followed by a data byte from the host. That byte is stored in one of six configuration registers.
- A status address is followed by eight bits that the slave shifts out from a 16-bit status input.
- Four routing addresses set the field-select and median-select flags directly from the address bits. The byte after a routing address is a dummy. The host needs to send it only when another transfer follows.

The serial clock, the data line and the reset strobe are all sampled in the fast system clock domain through two-flop synchronisers. Edges of the serial clock are detected there. The host's reset strobe realigns the bit framing: its falling edge clears the address register and aborts any partial transfer, so the next bit taken in is address bit 0. The bidirectional data line is split into an input, an output and an output enable, and the pad that joins them lives outside this block.

Top module: `ser_ctrl_slave`

## Requirements
- R1: While rst_ni is low, and after it is released with no serial activity, cfg_o is all zero, field_sel_o and median_sel_o are 0, and sdata_oe_o is 0.
- R2: An address A in 1..6 followed by 8 data bits updates cfg_o[8*(A-1)+7 : 8*(A-1)]. Both address and data are sent LSB first and sampled at rising edges of sclk_i. The other five registers keep their values.
- R3: A write to any other address that is not a status or routing address leaves cfg_o unchanged. This covers 0x00, 0x07..0x7B and 0x82..0xFF.
- R4: Addresses 0x7C..0x7F set field_sel_o to address bit 0 and median_sel_o to address bit 1. The flags take their new values once the eighth address bit is taken, before any data byte. The byte that follows changes no register.
- R5: After address 0x80 the slave shifts out status_i[7:0], and after 0x81 it shifts out status_i[15:8]. Bits go out LSB first. Bit k is on sdata_o at the (k+1)-th rising edge after the address, and is launched at the falling edge before it.
- R6: sdata_oe_o is 0 during address and write bytes. It rises only after the first falling sclk_i edge that follows a status address. It falls after the eighth read bit's rising edge.
- R7: A falling edge of strobe_i aborts any partial transfer and drops sdata_oe_o. The next bit received is address bit 0.
- R8: A falling edge of strobe_i does not change cfg_o, field_sel_o or median_sel_o.
- R9: Transfers follow one another back to back. A routing address may be followed by a dummy byte and then a new address, or by a strobe and then a new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than sclk_i |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Host serial clock, idles high |
| sdata_i | input | 1 | Serial data from the host |
| strobe_i | input | 1 | Framing reset strobe; its falling edge realigns |
| status_i | input | 16 | Status word offered for reading |
| sdata_o | output | 1 | Serial data to the host |
| sdata_oe_o | output | 1 | Enable for the data-line driver |
| cfg_o | output | 48 | Six configuration bytes; byte k is written at address k+1 |
| field_sel_o | output | 1 | Field-select routing flag |
| median_sel_o | output | 1 | Median-select routing flag |

## Verification
The main function is exercised with writes to every configuration address, each with a distinct bit pattern. These are followed by writes to unmapped addresses just below and above the map and just past the status pair; such writes must leave every byte untouched. All four routing addresses are sent in an order that toggles each flag independently. The flags are checked before the dummy byte, so that address-time action can be told apart from data-time action. Reads of both status addresses use asymmetric words, which expose swapped halves and reversed bit order. Strobes are issued in the middle of an address byte, after a routing address without its dummy byte, and in the middle of a read. Each is followed by a write, which shows whether the framing really restarted.

// File: rtl/ser_ctrl_pkg.sv
package ser_ctrl_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned NUM_CFG = 6;
  localparam logic [7:0] ROUTE_BASE = 8'h7C;  // 0x7C..0x7F, bit0 field, bit1 median
  localparam logic [7:0] STAT_BASE  = 8'h80;  // 0x80 low byte, 0x81 high byte

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_WR,
    PH_RD
  } phase_e;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int unsigned W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] st;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st <= {2{RST_VAL[i]}};
      else         st <= {st[0], d_i[i]};
    end
    assign q_o[i] = st[1];
  end
endmodule

// File: rtl/ser_frame.sv
module ser_frame
  import ser_ctrl_pkg::*;
#(
  parameter int unsigned BW   = BYTE_W,
  parameter int unsigned NCFG = NUM_CFG,
  localparam int unsigned IDX_W  = $clog2(NCFG),
  localparam int unsigned CNT_W  = $clog2(BW),
  localparam int unsigned STAT_W = 2 * BW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              strobe_i,
  input  logic [STAT_W-1:0] status_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [BW-1:0]     wr_data_o,
  output logic              route_en_o,
  output logic [1:0]        route_val_o,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic              sclk_rise_o,
  output logic              sclk_fall_o,
  output logic              strobe_fall_o
);
  phase_e            phase;
  logic [CNT_W-1:0]  cnt;
  logic [BW-1:0]     addr_q, dat_q, sh_q;
  logic              oe_q, sclk_d, strobe_d;

  logic [BW-1:0] addr_nx, dat_nx, rd_byte;
  logic          last, is_route, is_stat, cfg_hit;

  assign sclk_rise_o   = sclk_i & ~sclk_d;
  assign sclk_fall_o   = ~sclk_i & sclk_d;
  assign strobe_fall_o = ~strobe_i & strobe_d;

  assign addr_nx  = {sdata_i, addr_q[BW-1:1]};
  assign dat_nx   = {sdata_i, dat_q[BW-1:1]};
  assign last     = (cnt == CNT_W'(BW - 1));
  assign is_route = (addr_nx[BW-1:2] == ROUTE_BASE[BW-1:2]);
  assign is_stat  = (addr_nx[BW-1:1] == STAT_BASE[BW-1:1]);
  assign rd_byte  = addr_nx[0] ? status_i[STAT_W-1:BW] : status_i[BW-1:0];
  assign cfg_hit  = (addr_q != '0) && (addr_q <= BW'(NCFG));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d   <= 1'b1;
      strobe_d <= 1'b0;
    end else begin
      sclk_d   <= sclk_i;
      strobe_d <= strobe_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase       <= PH_ADDR;
      cnt         <= '0;
      addr_q      <= '0;
      dat_q       <= '0;
      sh_q        <= '0;
      oe_q        <= 1'b0;
      wr_en_o     <= 1'b0;
      wr_idx_o    <= '0;
      wr_data_o   <= '0;
      route_en_o  <= 1'b0;
      route_val_o <= '0;
    end else begin
      wr_en_o    <= 1'b0;
      route_en_o <= 1'b0;
      if (strobe_fall_o) begin
        phase  <= PH_ADDR;
        cnt    <= '0;
        addr_q <= '0;
        oe_q   <= 1'b0;
      end else if (sclk_rise_o) begin
        cnt <= cnt + 1'b1;
        unique case (phase)
          PH_ADDR: begin
            addr_q <= addr_nx;
            if (last) begin
              if (is_route) begin
                route_en_o  <= 1'b1;
                route_val_o <= addr_nx[1:0];
                phase       <= PH_WR;
              end else if (is_stat) begin
                sh_q  <= rd_byte;
                phase <= PH_RD;
              end else begin
                phase <= PH_WR;
              end
            end
          end
          PH_WR: begin
            dat_q <= dat_nx;
            if (last) begin
              if (cfg_hit) begin
                wr_en_o   <= 1'b1;
                wr_idx_o  <= IDX_W'(addr_q - 1'b1);
                wr_data_o <= dat_nx;
              end
              phase <= PH_ADDR;
            end
          end
          PH_RD: begin
            if (last) begin
              oe_q  <= 1'b0;
              phase <= PH_ADDR;
            end
          end
          default: phase <= PH_ADDR;
        endcase
      end else if (sclk_fall_o && phase == PH_RD) begin
        // first fall enables the driver on bit 0, later falls advance
        if (!oe_q) oe_q <= 1'b1;
        else       sh_q <= sh_q >> 1;
      end
    end
  end

  assign sdata_oe_o = oe_q;
  assign sdata_o    = oe_q & sh_q[0];
endmodule

// File: rtl/ser_cfg_regs.sv
module ser_cfg_regs
  import ser_ctrl_pkg::*;
#(
  parameter int unsigned BW   = BYTE_W,
  parameter int unsigned NCFG = NUM_CFG,
  localparam int unsigned IDX_W = $clog2(NCFG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [BW-1:0]      wr_data_i,
  input  logic               route_en_i,
  input  logic [1:0]         route_val_i,
  output logic [NCFG*BW-1:0] cfg_o,
  output logic               field_sel_o,
  output logic               median_sel_o
);
  for (genvar i = 0; i < NCFG; i++) begin : g_reg
    logic [BW-1:0] r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      r <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(i))        r <= wr_data_i;
    end
    assign cfg_o[i*BW +: BW] = r;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_sel_o  <= 1'b0;
      median_sel_o <= 1'b0;
    end else if (route_en_i) begin
      field_sel_o  <= route_val_i[0];
      median_sel_o <= route_val_i[1];
    end
  end
endmodule

// File: rtl/ser_ctrl_slave.sv
module ser_ctrl_slave
  import ser_ctrl_pkg::*;
#(
  parameter int unsigned BW   = BYTE_W,
  parameter int unsigned NCFG = NUM_CFG,
  localparam int unsigned IDX_W  = $clog2(NCFG),
  localparam int unsigned STAT_W = 2 * BW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               sdata_i,
  input  logic               strobe_i,
  input  logic [STAT_W-1:0]  status_i,
  output logic               sdata_o,
  output logic               sdata_oe_o,
  output logic [NCFG*BW-1:0] cfg_o,
  output logic               field_sel_o,
  output logic               median_sel_o
);
  logic [2:0]       raw, syn;
  logic             wr_en, route_en;
  logic [IDX_W-1:0] wr_idx;
  logic [BW-1:0]    wr_data;
  logic [1:0]       route_val;
  logic             sclk_rise, sclk_fall, strobe_fall;

  assign raw = {strobe_i, sdata_i, sclk_i};

  // serial clock idles high
  ser_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  ser_frame #(.BW(BW), .NCFG(NCFG)) u_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sclk_i       (syn[0]),
    .sdata_i      (syn[1]),
    .strobe_i     (syn[2]),
    .status_i     (status_i),
    .wr_en_o      (wr_en),
    .wr_idx_o     (wr_idx),
    .wr_data_o    (wr_data),
    .route_en_o   (route_en),
    .route_val_o  (route_val),
    .sdata_o      (sdata_o),
    .sdata_oe_o   (sdata_oe_o),
    .sclk_rise_o  (sclk_rise),
    .sclk_fall_o  (sclk_fall),
    .strobe_fall_o(strobe_fall)
  );

  ser_cfg_regs #(.BW(BW), .NCFG(NCFG)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_idx_i    (wr_idx),
    .wr_data_i   (wr_data),
    .route_en_i  (route_en),
    .route_val_i (route_val),
    .cfg_o       (cfg_o),
    .field_sel_o (field_sel_o),
    .median_sel_o(median_sel_o)
  );
endmodule

// File: rtl/ser_ctrl_slave_chk.sv
module ser_ctrl_slave_chk #(
  parameter int unsigned CW = 48
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sclk_rise,
  input logic          sclk_fall,
  input logic          strobe_fall,
  input logic          sdata_o,
  input logic          sdata_oe_o,
  input logic [CW-1:0] cfg_o,
  input logic          field_sel_o,
  input logic          median_sel_o
);
  p_cfg_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sclk_rise) |=> $stable(cfg_o));

  p_route_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sclk_rise) |=> $stable({field_sel_o, median_sel_o}));

  p_oe_on_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdata_oe_o) |-> $past(sclk_fall));

  p_oe_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sdata_oe_o) |-> ($past(sclk_rise) || $past(strobe_fall)));

  p_bit_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdata_oe_o && !sclk_fall) |=> (!sdata_oe_o || $stable(sdata_o)));

  p_strobe_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_fall |=> !sdata_oe_o);
endmodule

bind ser_ctrl_slave ser_ctrl_slave_chk #(.CW(NCFG * BW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sclk_rise   (sclk_rise),
  .sclk_fall   (sclk_fall),
  .strobe_fall (strobe_fall),
  .sdata_o     (sdata_o),
  .sdata_oe_o  (sdata_oe_o),
  .cfg_o       (cfg_o),
  .field_sel_o (field_sel_o),
  .median_sel_o(median_sel_o)
);

// File: tb/sim_ser_ctrl_slave.sv
`timescale 1ns/1ps
module sim_ser_ctrl_slave;
  localparam int H    = 12;
  localparam int NREG = 6;
  localparam int NV   = 16;
  // {kind, addr, data}: kind 0 write, 1 routing, 2 status read
  localparam logic [23:0] VEC [NV] = '{
    {8'd0, 8'h01, 8'hA5}, {8'd0, 8'h02, 8'h3C}, {8'd0, 8'h03, 8'h81},
    {8'd0, 8'h04, 8'h7E}, {8'd0, 8'h05, 8'h0F}, {8'd0, 8'h06, 8'hF0},
    {8'd0, 8'h00, 8'hFF}, {8'd0, 8'h07, 8'h55}, {8'd0, 8'h82, 8'hAA},
    {8'd1, 8'h7D, 8'h00}, {8'd1, 8'h7E, 8'h00}, {8'd1, 8'h7F, 8'h00},
    {8'd1, 8'h7C, 8'h00}, {8'd2, 8'h80, 8'h96}, {8'd2, 8'h81, 8'h69},
    {8'd0, 8'h03, 8'hC3}
  };

  logic clk = 0, rst_ni = 0, sclk = 1, sdata = 0, strobe = 0;
  logic [15:0] status = '0;
  logic sdata_o, oe, fsel, msel;
  logic [47:0] cfg;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_cfg [NREG];
  logic exp_f = 0, exp_m = 0;

  always #2 clk = ~clk;

  ser_ctrl_slave u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdata_i(sdata),
    .strobe_i(strobe), .status_i(status), .sdata_o(sdata_o),
    .sdata_oe_o(oe), .cfg_o(cfg), .field_sel_o(fsel), .median_sel_o(msel)
  );

  function automatic logic [47:0] exp_flat();
    logic [47:0] r;
    for (int i = 0; i < NREG; i++) r[i*8 +: 8] = exp_cfg[i];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b);
    @(negedge clk); sclk = 0; sdata = b;
    idle(H);
    sclk = 1;
    idle(H);
  endtask

  task automatic sbyte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) sbit(v[i]);
  endtask

  task automatic rbyte(output logic [7:0] v, output logic oe_all);
    oe_all = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sclk = 0; sdata = 0;
      idle(H);
      v[i] = sdata_o;
      oe_all &= oe;
      sclk = 1;
      idle(H);
    end
  endtask

  task automatic pulse_strobe();
    @(negedge clk); strobe = 1; idle(8);
    strobe = 0; idle(8);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    sbyte(a); sbyte(d);
    if (a >= 8'd1 && a <= 8'd6) exp_cfg[a-1] = d;
    idle(4);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] k, a, d, got;
    logic oe_all;
    for (int i = 0; i < NREG; i++) exp_cfg[i] = '0;
    idle(3);
    chk("R1 cfg in reset", cfg, '0);
    chk("R1 oe in reset", {47'd0, oe}, '0);
    rst_ni = 1;
    idle(6);
    chk("R1 cfg after reset", cfg, '0);
    chk("R1 flags after reset", {46'd0, fsel, msel}, '0);
    chk("R1 oe after reset", {47'd0, oe}, '0);

    for (int v = 0; v < NV; v++) begin
      {k, a, d} = VEC[v];
      case (k)
        8'd0: begin
          wr(a, d);
          chk((a >= 8'd1 && a <= 8'd6) ? "R2 write" : "R3 unmapped write", cfg, exp_flat());
        end
        8'd1: begin
          sbyte(a);
          idle(4);
          exp_f = a[0]; exp_m = a[1];
          chk("R4 routing flags at address", {46'd0, fsel, msel}, {46'd0, exp_f, exp_m});
          chk("R6 oe low after routing addr", {47'd0, oe}, '0);
          sbyte(8'hFF);
          idle(4);
          chk("R4 dummy byte no write", cfg, exp_flat());
        end
        default: begin
          status = {d ^ 8'h3C, d};
          sbyte(a);
          idle(2);
          chk("R6 oe low before first fall", {47'd0, oe}, '0);
          rbyte(got, oe_all);
          chk("R5 status read", {40'd0, got}, {40'd0, a[0] ? (d ^ 8'h3C) : d});
          chk("R6 oe held during read", {47'd0, oe_all}, 48'd1);
          idle(4);
          chk("R6 oe released", {47'd0, oe}, '0);
        end
      endcase
    end

    // R7/R8: strobe in the middle of an address byte
    sbit(1); sbit(1); sbit(1);
    pulse_strobe();
    chk("R8 cfg kept over strobe", cfg, exp_flat());
    chk("R8 flags kept over strobe", {46'd0, fsel, msel}, {46'd0, exp_f, exp_m});
    wr(8'h02, 8'h5A);
    chk("R7 realigned write", cfg, exp_flat());

    // R9: routing address without dummy, then strobe, then a write
    sbyte(8'h7F);
    pulse_strobe();
    exp_f = 1; exp_m = 1;
    chk("R9 flags without dummy", {46'd0, fsel, msel}, 48'd3);
    wr(8'h04, 8'h11);
    chk("R9 write after strobe", cfg, exp_flat());

    // R9: routing address with dummy, then a read
    sbyte(8'h7E); sbyte(8'h00);
    exp_f = 0; exp_m = 1;
    status = 16'hBEEF;
    sbyte(8'h80);
    rbyte(got, oe_all);
    chk("R9 read after dummy", {40'd0, got}, 48'hEF);
    chk("R4 flags 7E", {46'd0, fsel, msel}, 48'd1);

    // R7: strobe during a read drops the driver
    sbyte(8'h81);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); sclk = 0; idle(H); sclk = 1; idle(H);
    end
    chk("R6 oe high mid read", {47'd0, oe}, 48'd1);
    pulse_strobe();
    chk("R7 oe dropped by strobe", {47'd0, oe}, '0);
    wr(8'h06, 8'h99);
    chk("R7 write after aborted read", cfg, exp_flat());

    // R1: asynchronous reset mid-run
    @(negedge clk); rst_ni = 0;
    idle(2);
    chk("R1 cfg async clear", cfg, '0);
    chk("R1 flags async clear", {46'd0, fsel, msel}, '0);
    rst_ni = 1;
    idle(4);

    done = 1;
    summary();
    $finish;
  end
endmodule